// File: doc/BRIEF.md
# Paged Indirect Register Access Sequencer

This block lets a host reach a paged internal register file that sits behind a 16-bit management register port. It works like a Clause-22 port, but with none of the serial pin framing. The host hands over one command, which says:
- read or write,
- an 8-bit page,
- an 8-bit register offset,
- a width code,
- up to 64 bits of write data.

The sequencer expands that command into a chain of 16-bit accesses to a fixed management address:
1. A page-select write.
2. An operation-trigger write.
3. A series of busy polls, spaced by a timed wait.
4. A run of 16-bit data-register transfers. For a write these come first, before step 1; for a read they come last.

When the chain ends, the sequencer gives the host a one-cycle completion pulse. The pulse carries the assembled read data and a status code. The status reports one of: success, completion timeout, an error signalled by the management bus, or an illegal width code.

The management side is a plain request/acknowledge bus. A request and its fields stay put until the slave acknowledges it. The slave may flag an error together with the acknowledge.

Top module: `paged_reg_master`

## Requirements
- R1: Every management request carries the fixed management address 30 on `mb_phy`.
- R2: The page-select step writes register 0x10 with the page in bits 15:8, bits 7:1 zero and bit 0 set.
- R3: The trigger step writes register 0x11 with the offset in bits 15:8 and bits 7:2 zero. Bit 0 is set for a write command and bit 1 for a read command, never both.
- R4: A write command loads the data registers before the page-select step, in ascending order starting at 0x18, chunk k carrying data bits 16k+15:16k. The chunk count follows the width code: 0 (8-bit) 1, 1 (16-bit) 1, 2 (32-bit) 2, 3 (48-bit) 3, 4 (64-bit) 4. For an 8-bit write the upper byte of 0x18 is zero.
- R5: A read command reads the data registers only after completion is seen, ascending from 0x18 with the same chunk count as R4. It returns chunk k in bits 16k+15:16k. Bits above the width are zero; an 8-bit read keeps only the low byte of 0x18.
- R6: Completion is found by reading register 0x11 until bits 1:0 are both zero. At most 5 such reads are made, and consecutive reads are at least CLK_HZ/1e6*POLL_US clock cycles apart.
- R7: If the fifth poll still shows an operation bit set, the command ends with status 1, read data zero, and no data-register reads.
- R8: An acknowledge with `mb_err` high ends the command at once: no further request is raised, and the completion carries status 2 with zero data.
- R9: A width code of 5, 6 or 7 completes on the cycle after acceptance with status 3 and makes no management access.
- R10: `cmd_ready` is high only when no command is in progress. `done` is a one-cycle pulse, and successful commands report status 0; writes return zero data.
- R11: While `mb_req` is high and unacknowledged, `mb_we`, `mb_reg` and `mb_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken when valid is high |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_page | input | 8 | Target page |
| cmd_offset | input | 8 | Register offset within the page |
| cmd_width | input | 3 | Width code: 0=8, 1=16, 2=32, 3=48, 4=64 bits |
| cmd_wdata | input | 64 | Write data, least significant bits used per width |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 timeout, 2 bus error, 3 bad width |
| done_rdata | output | 64 | Read result, valid with `done` |
| mb_req | output | 1 | Management access request |
| mb_we | output | 1 | 1 = register write, 0 = register read |
| mb_phy | output | 5 | Management device address |
| mb_reg | output | 5 | Management register number |
| mb_wdata | output | 16 | Register write value |
| mb_ack | input | 1 | Access acknowledge, one cycle |
| mb_rdata | input | 16 | Register read value, valid with ack |
| mb_err | input | 1 | Access failed, valid with ack |

## Verification
The hardest situations to reach are the edges of the completion poll. In one, the operation bits clear on exactly the fifth and last allowed poll. In the other, they never clear and the command must stop without touching the data registers. The bench model of the register file holds the operation bits set for a programmable number of polls per command (0, 2, 4 and 5). It time-stamps every acknowledged access, so the poll count and the spacing between polls can be checked. The model can also fail one chosen access in the middle of a wide write, and the bench then confirms that the request line stays low afterwards.

// File: rtl/prm_pkg.sv
package prm_pkg;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_TIMEOUT  = 2'd1,
    ST_BUSERR   = 2'd2,
    ST_BADWIDTH = 2'd3
  } status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DATA_WR,
    S_PAGE,
    S_OPER,
    S_POLL,
    S_WAIT,
    S_DATA_RD
  } seq_state_e;

  localparam logic [4:0] REG_PAGE  = 5'h10;
  localparam logic [4:0] REG_OPER  = 5'h11;
  localparam logic [4:0] REG_DATA0 = 5'h18;

  localparam logic [2:0] WCODE_MAX = 3'd4;

  // number of 16-bit chunks moved for a width code
  function automatic logic [2:0] chunk_count(input logic [2:0] code);
    case (code)
      3'd0, 3'd1: chunk_count = 3'd1;
      3'd2:       chunk_count = 3'd2;
      3'd3:       chunk_count = 3'd3;
      default:    chunk_count = 3'd4;
    endcase
  endfunction

  // number of meaningful bits for a width code
  function automatic int unsigned width_bits(input logic [2:0] code);
    if (code == 3'd0) width_bits = 8;
    else              width_bits = 16 * int'(chunk_count(code));
  endfunction

endpackage

// File: rtl/prm_poll_timer.sv
module prm_poll_timer #(
  parameter int unsigned WAIT_CYC = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expire
);
  localparam int unsigned CNTW = $clog2(WAIT_CYC + 1);

  logic [CNTW-1:0] cnt;
  logic            running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (start) begin
        cnt     <= CNTW'(WAIT_CYC);
        running <= 1'b1;
      end else if (running) begin
        if (cnt <= CNTW'(1)) begin
          running <= 1'b0;
          expire  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R6
  gap_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !expire);

  // R6
  single_expire_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);

endmodule

// File: rtl/prm_data_path.sv
module prm_data_path
  import prm_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned CW = 16,
  parameter int unsigned IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] wdata_in,
  input  logic [2:0]    width_in,
  input  logic [IW-1:0] idx,
  output logic [CW-1:0] wchunk,
  input  logic          cap_en,
  input  logic [CW-1:0] cap_data,
  output logic [DW-1:0] rd_merged
);
  localparam int unsigned NCH = DW / CW;

  logic [DW-1:0] wreg;
  logic [DW-1:0] rbuf;
  logic [2:0]    wq;
  logic [CW-1:0] wsel   [NCH];
  logic [DW-1:0] merged;

  function automatic logic [DW-1:0] keep_mask(input logic [2:0] code);
    logic [DW-1:0] m;
    m = '0;
    for (int b = 0; b < int'(DW); b++)
      if (b < int'(width_bits(code))) m[b] = 1'b1;
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wreg <= '0;
      rbuf <= '0;
      wq   <= '0;
    end else if (load) begin
      wreg <= wdata_in & keep_mask(width_in);
      rbuf <= '0;
      wq   <= width_in;
    end else if (cap_en) begin
      for (int g = 0; g < int'(NCH); g++)
        if (idx == IW'(g)) rbuf[g*CW +: CW] <= cap_data;
    end
  end

  for (genvar g = 0; g < int'(NCH); g++) begin : g_chunk
    assign wsel[g] = wreg[g*CW +: CW];
    assign merged[g*CW +: CW] = (cap_en && idx == IW'(g)) ? cap_data
                                                          : rbuf[g*CW +: CW];
  end

  assign wchunk    = wsel[idx];
  assign rd_merged = merged & keep_mask(wq);

endmodule

// File: rtl/paged_reg_master.sv
module paged_reg_master
  import prm_pkg::*;
#(
  parameter int unsigned DW       = 64,
  parameter int unsigned CW       = 16,
  parameter int unsigned AW       = 8,
  parameter logic [4:0]  PHY_ADDR = 5'd30,
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned POLL_US  = 100,
  parameter int unsigned POLL_MAX = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_page,
  input  logic [AW-1:0] cmd_offset,
  input  logic [2:0]    cmd_width,
  input  logic [DW-1:0] cmd_wdata,
  output logic          done,
  output logic [1:0]    done_status,
  output logic [DW-1:0] done_rdata,
  output logic          mb_req,
  output logic          mb_we,
  output logic [4:0]    mb_phy,
  output logic [4:0]    mb_reg,
  output logic [CW-1:0] mb_wdata,
  input  logic          mb_ack,
  input  logic [CW-1:0] mb_rdata,
  input  logic          mb_err
);
  localparam int unsigned NCH      = DW / CW;
  localparam int unsigned IW       = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned WAIT_CYC = (CLK_HZ / 1_000_000) * POLL_US;
  localparam int unsigned PCW      = $clog2(POLL_MAX + 1);

  seq_state_e    state;
  logic          is_wr;
  logic [AW-1:0] page_q;
  logic [AW-1:0] off_q;
  logic [2:0]    nchunk_q;
  logic [IW-1:0] idx;
  logic [PCW-1:0] poll_cnt;
  logic          timer_start;
  logic          timer_expire;
  logic          accept;
  logic          bus_state;
  logic          hit;
  logic          last_chunk;
  logic          l_we;
  logic [4:0]    l_reg;
  logic [CW-1:0] l_wd;
  logic [CW-1:0] wchunk;
  logic          cap_en;
  logic [DW-1:0] rd_merged;

  assign cmd_ready  = (state == S_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign mb_phy     = PHY_ADDR;
  assign hit        = mb_req && mb_ack;
  assign last_chunk = (idx == IW'(nchunk_q - 3'd1));
  assign bus_state  = (state == S_DATA_WR) || (state == S_PAGE) ||
                      (state == S_OPER)    || (state == S_POLL) ||
                      (state == S_DATA_RD);
  assign cap_en     = (state == S_DATA_RD) && hit && !mb_err;

  // fields of the next request, decoded from the step
  always_comb begin
    l_we  = 1'b1;
    l_reg = REG_PAGE;
    l_wd  = '0;
    case (state)
      S_DATA_WR: begin
        l_reg = REG_DATA0 + 5'(idx);
        l_wd  = wchunk;
      end
      S_PAGE:    l_wd = {page_q, {(CW-AW-1){1'b0}}, 1'b1};
      S_OPER: begin
        l_reg = REG_OPER;
        l_wd  = {off_q, {(CW-AW-2){1'b0}}, ~is_wr, is_wr};
      end
      S_POLL: begin
        l_we  = 1'b0;
        l_reg = REG_OPER;
      end
      S_DATA_RD: begin
        l_we  = 1'b0;
        l_reg = REG_DATA0 + 5'(idx);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      is_wr       <= 1'b0;
      page_q      <= '0;
      off_q       <= '0;
      nchunk_q    <= 3'd1;
      idx         <= '0;
      poll_cnt    <= '0;
      timer_start <= 1'b0;
      done        <= 1'b0;
      done_status <= ST_OK;
      done_rdata  <= '0;
      mb_req      <= 1'b0;
      mb_we       <= 1'b0;
      mb_reg      <= '0;
      mb_wdata    <= '0;
    end else begin
      done        <= 1'b0;
      timer_start <= 1'b0;

      if (bus_state && !mb_req) begin
        mb_req   <= 1'b1;
        mb_we    <= l_we;
        mb_reg   <= l_reg;
        mb_wdata <= l_wd;
      end else if (hit) begin
        mb_req <= 1'b0;
      end

      case (state)
        S_IDLE: begin
          if (accept) begin
            is_wr    <= cmd_write;
            page_q   <= cmd_page;
            off_q    <= cmd_offset;
            nchunk_q <= chunk_count(cmd_width);
            idx      <= '0;
            poll_cnt <= '0;
            if (cmd_width > WCODE_MAX) begin
              done        <= 1'b1;
              done_status <= ST_BADWIDTH;
              done_rdata  <= '0;
            end else begin
              state <= cmd_write ? S_DATA_WR : S_PAGE;
            end
          end
        end

        S_WAIT: if (timer_expire) state <= S_POLL;

        default: begin
          if (hit && mb_err) begin
            state       <= S_IDLE;
            done        <= 1'b1;
            done_status <= ST_BUSERR;
            done_rdata  <= '0;
          end else if (hit) begin
            case (state)
              S_DATA_WR: begin
                if (last_chunk) begin
                  idx   <= '0;
                  state <= S_PAGE;
                end else begin
                  idx <= idx + 1'b1;
                end
              end
              S_PAGE: state <= S_OPER;
              S_OPER: state <= S_POLL;
              S_POLL: begin
                if (mb_rdata[1:0] == 2'b00) begin
                  if (is_wr) begin
                    state       <= S_IDLE;
                    done        <= 1'b1;
                    done_status <= ST_OK;
                    done_rdata  <= '0;
                  end else begin
                    idx   <= '0;
                    state <= S_DATA_RD;
                  end
                end else if (poll_cnt == PCW'(POLL_MAX - 1)) begin
                  state       <= S_IDLE;
                  done        <= 1'b1;
                  done_status <= ST_TIMEOUT;
                  done_rdata  <= '0;
                end else begin
                  poll_cnt    <= poll_cnt + 1'b1;
                  timer_start <= 1'b1;
                  state       <= S_WAIT;
                end
              end
              S_DATA_RD: begin
                if (last_chunk) begin
                  state       <= S_IDLE;
                  done        <= 1'b1;
                  done_status <= ST_OK;
                  done_rdata  <= rd_merged;
                end else begin
                  idx <= idx + 1'b1;
                end
              end
              default: state <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  prm_data_path #(.DW(DW), .CW(CW), .IW(IW)) data_i (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .wdata_in  (cmd_wdata),
    .width_in  (cmd_width),
    .idx       (idx),
    .wchunk    (wchunk),
    .cap_en    (cap_en),
    .cap_data  (mb_rdata),
    .rd_merged (rd_merged)
  );

  prm_poll_timer #(.WAIT_CYC(WAIT_CYC)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .start  (timer_start),
    .expire (timer_expire)
  );

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mb_req && !mb_ack) |=> (mb_req && $stable(mb_we) && $stable(mb_reg) && $stable(mb_wdata)));

  // R8
  err_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (mb_req && mb_ack && mb_err) |=> (!mb_req && done && done_status == ST_BUSERR));

  // R9
  bad_width_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_width > WCODE_MAX) |=>
      (done && done_status == ST_BADWIDTH && !mb_req));

  // R7
  timeout_count_chk: assert property (@(posedge clk) disable iff (rst)
    (done && done_status == ST_TIMEOUT) |-> (poll_cnt == PCW'(POLL_MAX - 1)));

  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    mb_req |-> !cmd_ready);

endmodule

// File: tb/paged_reg_master_tb.sv
module paged_reg_master_tb_top;
  localparam int unsigned CLK_HZ  = 50_000_000;
  localparam int unsigned POLL_US = 100;
  localparam int unsigned WAIT    = (CLK_HZ / 1_000_000) * POLL_US;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [7:0]  cmd_page = '0;
  logic [7:0]  cmd_offset = '0;
  logic [2:0]  cmd_width = '0;
  logic [63:0] cmd_wdata = '0;
  logic        done;
  logic [1:0]  done_status;
  logic [63:0] done_rdata;
  logic        mb_req, mb_we;
  logic [4:0]  mb_phy, mb_reg;
  logic [15:0] mb_wdata;
  logic        mb_ack = 1'b0;
  logic [15:0] mb_rdata = '0;
  logic        mb_err = 1'b0;

  always #10 clk = ~clk;

  paged_reg_master #(.CLK_HZ(CLK_HZ), .POLL_US(POLL_US)) dut_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_page(cmd_page), .cmd_offset(cmd_offset), .cmd_width(cmd_width),
    .cmd_wdata(cmd_wdata),
    .done(done), .done_status(done_status), .done_rdata(done_rdata),
    .mb_req(mb_req), .mb_we(mb_we), .mb_phy(mb_phy), .mb_reg(mb_reg),
    .mb_wdata(mb_wdata), .mb_ack(mb_ack), .mb_rdata(mb_rdata), .mb_err(mb_err)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int nchunks(input logic [2:0] w);
    return (w <= 3'd1) ? 1 : int'(w);
  endfunction

  function automatic logic [63:0] trim(input logic [2:0] w, input logic [63:0] v);
    case (w)
      3'd0: return {56'd0, v[7:0]};
      3'd1: return {48'd0, v[15:0]};
      3'd2: return {32'd0, v[31:0]};
      3'd3: return {16'd0, v[47:0]};
      default: return v;
    endcase
  endfunction

  // ---------------- register-file model on the management bus ----------------
  logic [15:0] m_page, m_oper;
  logic [15:0] m_data [4];
  logic [63:0] mem [logic [15:0]];
  int busy_cfg = 0, busy_left = 0, err_cfg = 0, acc_n = 0, lat = 0;
  int log_n = 0, hold_bad = 0;
  bit pend = 0;
  logic [21:0] pend_f;
  logic        log_we  [32];
  logic [4:0]  log_reg [32];
  logic [4:0]  log_phy [32];
  logic [15:0] log_wd  [32];
  int          log_cyc [32];

  always @(negedge clk) begin
    mb_ack = 1'b0;
    mb_err = 1'b0;
    if (pend && mb_req && {mb_we, mb_reg, mb_wdata} != pend_f) hold_bad++;
    if (mb_req && !rst) begin
      if (lat < 1) lat++;
      else begin
        lat = 0;
        acc_n++;
        mb_ack = 1'b1;
        if (log_n < 32) begin
          log_we[log_n] = mb_we; log_reg[log_n] = mb_reg; log_phy[log_n] = mb_phy;
          log_wd[log_n] = mb_wdata; log_cyc[log_n] = cyc;
        end
        log_n++;
        if (acc_n == err_cfg) mb_err = 1'b1;
        else if (mb_we) begin
          if (mb_reg == 5'h10) m_page = mb_wdata;
          else if (mb_reg == 5'h11) begin
            m_oper = mb_wdata;
            busy_left = busy_cfg;
            if (mb_wdata[0])
              mem[{m_page[15:8], mb_wdata[15:8]}] = {m_data[3], m_data[2], m_data[1], m_data[0]};
            if (mb_wdata[1]) begin
              logic [63:0] v;
              v = mem.exists({m_page[15:8], mb_wdata[15:8]}) ? mem[{m_page[15:8], mb_wdata[15:8]}] : 64'd0;
              for (int k = 0; k < 4; k++) m_data[k] = v[16*k +: 16];
            end
          end else if (mb_reg >= 5'h18 && mb_reg <= 5'h1B) m_data[mb_reg - 5'h18] = mb_wdata;
        end else begin
          if (mb_reg == 5'h11) begin
            if (busy_left > 0) begin
              mb_rdata = {m_oper[15:8], 6'd0, m_oper[1:0]};
              busy_left--;
            end else mb_rdata = {m_oper[15:8], 8'd0};
          end else if (mb_reg >= 5'h18 && mb_reg <= 5'h1B) mb_rdata = m_data[mb_reg - 5'h18];
          else mb_rdata = 16'hDEAD;
        end
      end
    end
    pend   = mb_req && !mb_ack;
    pend_f = {mb_we, mb_reg, mb_wdata};
  end

  // ---------------- scoreboard ----------------
  logic [65:0] sb_q [$];

  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb_q.size() == 0) check(0, "R10 unexpected done", 64'(done_status), 64'd0);
      else begin
        logic [65:0] e;
        e = sb_q.pop_front();
        check(done_status == e[65:64], "R10 completion status", 64'(done_status), 64'(e[65:64]));
        check(done_rdata == e[63:0], "R5 completion data", done_rdata, e[63:0]);
      end
    end
  end

  task automatic run_cmd(input bit wr, input logic [7:0] pg, input logic [7:0] off,
                         input logic [2:0] w, input logic [63:0] wd, input int busy,
                         input int err_at, input logic [1:0] es, input logic [63:0] er);
    busy_cfg = busy; err_cfg = err_at; acc_n = 0; log_n = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_page = pg; cmd_offset = off;
    cmd_width = w; cmd_wdata = wd;
    sb_q.push_back({es, er});
    @(negedge clk);
    cmd_valid = 1'b0;
    // R10 ready drops while a legal command runs
    if (w <= 3'd4) check(cmd_ready == 1'b0, "R10 ready low when busy", 64'(cmd_ready), 64'd0);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R10 done is one cycle", 64'(done), 64'd0);
  endtask

  // compare the logged access chain with the one the requirements define
  task automatic check_seq(input bit wr, input logic [7:0] pg, input logic [7:0] off,
                           input logic [2:0] w, input logic [63:0] wd, input int busy);
    logic        e_we  [32];
    logic [4:0]  e_reg [32];
    logic [15:0] e_wd  [32];
    int n = 0, polls, bad = -1, phy_bad = 0, first_poll = -1;
    int nc = nchunks(w);
    if (wr) for (int i = 0; i < nc; i++) begin
      e_we[n] = 1; e_reg[n] = 5'(8'h18 + i);
      e_wd[n] = (w == 3'd0) ? {8'd0, wd[7:0]} : wd[16*i +: 16]; n++;
    end
    e_we[n] = 1; e_reg[n] = 5'h10; e_wd[n] = {pg, 8'h01}; n++;
    e_we[n] = 1; e_reg[n] = 5'h11; e_wd[n] = {off, wr ? 8'h01 : 8'h02}; n++;
    polls = (busy + 1 > 5) ? 5 : busy + 1;
    first_poll = n;
    for (int i = 0; i < polls; i++) begin e_we[n] = 0; e_reg[n] = 5'h11; e_wd[n] = 0; n++; end
    if (!wr && busy < 5) for (int i = 0; i < nc; i++) begin
      e_we[n] = 0; e_reg[n] = 5'(8'h18 + i); e_wd[n] = 0; n++;
    end
    check(log_n == n, "R6 access count", 64'(log_n), 64'(n));
    for (int i = 0; i < n && i < log_n; i++) begin
      if (log_phy[i] != 5'd30) phy_bad++;
      if (bad < 0 && (log_we[i] != e_we[i] || log_reg[i] != e_reg[i] ||
                      (e_we[i] && log_wd[i] != e_wd[i]))) bad = i;
    end
    check(phy_bad == 0, "R1 management address 30", 64'(phy_bad), 64'd0);
    if (bad >= 0)
      check(0, wr ? "R4 R2 R3 write chain" : "R5 R2 R3 read chain",
            {43'd0, log_we[bad], log_reg[bad], log_wd[bad]},
            {43'd0, e_we[bad], e_reg[bad], e_wd[bad]});
    else check(1, "R2 R3 R4 R5 chain", 0, 0);
    for (int i = first_poll + 1; i < first_poll + polls && i < log_n; i++)
      check(log_cyc[i] - log_cyc[i-1] >= int'(WAIT), "R6 poll spacing",
            64'(log_cyc[i] - log_cyc[i-1]), 64'(WAIT));
  endtask

  initial begin
    int wd_cnt;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R10 reset ready", 64'(cmd_ready), 64'd1);
    check(done == 1'b0, "R10 reset done", 64'(done), 64'd0);
    check(mb_req == 1'b0, "R8 reset no request", 64'(mb_req), 64'd0);

    // R4 64-bit write, immediate completion
    run_cmd(1, 8'h12, 8'h34, 3'd4, 64'h0123_4567_89AB_CDEF, 0, 0, 2'd0, 64'd0);
    check_seq(1, 8'h12, 8'h34, 3'd4, 64'h0123_4567_89AB_CDEF, 0);
    // R5 R6 64-bit read, two busy polls
    run_cmd(0, 8'h12, 8'h34, 3'd4, 64'h0, 2, 0, 2'd0, 64'h0123_4567_89AB_CDEF);
    check_seq(0, 8'h12, 8'h34, 3'd4, 64'h0, 2);
    // R5 8-bit read keeps low byte
    run_cmd(0, 8'h12, 8'h34, 3'd0, 64'h0, 0, 0, 2'd0, 64'hEF);
    check_seq(0, 8'h12, 8'h34, 3'd0, 64'h0, 0);
    // R4 32-bit write then read
    run_cmd(1, 8'h05, 8'h20, 3'd2, 64'hFFFF_FFFF_DEAD_BEEF, 0, 0, 2'd0, 64'd0);
    check_seq(1, 8'h05, 8'h20, 3'd2, 64'hFFFF_FFFF_DEAD_BEEF, 0);
    run_cmd(0, 8'h05, 8'h20, 3'd2, 64'h0, 0, 0, 2'd0, 64'hDEAD_BEEF);
    // R4 48-bit write then read
    run_cmd(1, 8'hA0, 8'h07, 3'd3, 64'h1111_AAAA_BBBB_CCCC, 0, 0, 2'd0, 64'd0);
    check_seq(1, 8'hA0, 8'h07, 3'd3, 64'h1111_AAAA_BBBB_CCCC, 0);
    run_cmd(0, 8'hA0, 8'h07, 3'd3, 64'h0, 0, 0, 2'd0, 64'h0000_AAAA_BBBB_CCCC);
    check_seq(0, 8'hA0, 8'h07, 3'd3, 64'h0, 0);
    // R4 8-bit write puts zero in the upper byte
    run_cmd(1, 8'h01, 8'hFF, 3'd0, 64'h1234_5678_9ABC_DE5A, 0, 0, 2'd0, 64'd0);
    check_seq(1, 8'h01, 8'hFF, 3'd0, 64'h1234_5678_9ABC_DE5A, 0);
    run_cmd(0, 8'h01, 8'hFF, 3'd1, 64'h0, 0, 0, 2'd0, 64'h005A);
    // R6 completion on the fifth and last poll
    run_cmd(1, 8'h33, 8'h44, 3'd1, 64'hBEEF, 4, 0, 2'd0, 64'd0);
    check_seq(1, 8'h33, 8'h44, 3'd1, 64'hBEEF, 4);
    // R7 never completes: timeout, no data reads
    run_cmd(0, 8'h33, 8'h44, 3'd1, 64'h0, 5, 0, 2'd1, 64'd0);
    check_seq(0, 8'h33, 8'h44, 3'd1, 64'h0, 5);
    // R8 bus error on the second data write
    run_cmd(1, 8'h40, 8'h41, 3'd4, 64'hFACE_FACE_FACE_FACE, 0, 2, 2'd2, 64'd0);
    repeat (4) @(negedge clk);
    check(log_n == 2, "R8 no access after error", 64'(log_n), 64'd2);
    check(mb_req == 1'b0, "R8 request idle after error", 64'(mb_req), 64'd0);
    // R9 illegal width codes
    run_cmd(1, 8'h01, 8'h02, 3'd6, 64'h55, 0, 0, 2'd3, 64'd0);
    check(log_n == 0, "R9 no access for bad width", 64'(log_n), 64'd0);
    run_cmd(0, 8'h01, 8'h02, 3'd5, 64'h0, 0, 0, 2'd3, 64'd0);
    check(log_n == 0, "R9 no access for bad width", 64'(log_n), 64'd0);
    // R11 request fields held until acknowledge
    check(hold_bad == 0, "R11 request stable", 64'(hold_bad), 64'd0);
    check(sb_q.size() == 0, "R10 all completions seen", 64'(sb_q.size()), 64'd0);

    wd_cnt = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    while (cyc < 190000) @(posedge clk);
    check(0, "R10 watchdog expired", 64'(cyc), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule